// File: doc/BRIEF.md
# Video Sync Output Stage with One-Shot Frame Capture

This block sits between an interlaced video timing generator and the sensor's output pins. It receives raw, active-high horizontal sync, composite sync, vertical sync, line-valid and odd-field indications. It drives four registered output pins: horizontal sync, a selectable horizontal or composite sync, vertical sync and a line-valid strobe. Static configuration inputs choose one of four fixed polarity patterns for the three sync pins. They also choose whether vertical sync appears in every field or only in odd fields, what the selectable sync pin carries, and whether the line-valid strobe is inverted.

The block also carries a one-shot frame capture request. After the request is raised, the line-valid strobe is held inactive until the next odd field begins. It is then passed for exactly that odd field and the even field after it, which together form one frame. The request flag then drops by itself. A field begins on the rising edge of raw vertical sync, and the field parity is sampled from the odd-field input on that same cycle. While field-drop mode is on, capture requests are ignored. Software may withdraw a request. If the request is withdrawn before its frame starts, the capture is cancelled. If it is withdrawn during the captured frame, only the flag drops, and the frame's line-valid strobe continues unchanged.

Top module: `video_sync_gate`

## Requirements
- R1: While reset is asserted, all five outputs (`hsync_o`, `chsync_o`, `vsync_o`, `href_o`, `snap_pending_o`) are 0, whatever the inputs.
- R2: `cfg_sync_pol` sets each sync pin to either active-high (pin equals the asserted signal) or active-low (pin is the inverse). Written as (hsync, chsync, vsync), the codes map as follows: 0 gives (low, low, high), 1 gives (low, low, low), 2 gives (high, low, high) and 3 gives (low, high, high).
- R3: With `cfg_vs_frame`=1, vertical sync is asserted only while `raw_odd_field`=1. With `cfg_vs_frame`=0, it follows `raw_vsync` in every field.
- R4: `chsync_o` carries composite sync when `cfg_chs_composite`=1 and horizontal sync when it is 0.
- R5: When no capture is armed, `href_o` equals `raw_line_valid`, XOR-ed with `cfg_href_invert`.
- R6: A one-cycle `snap_set` pulse while idle, with field-drop off, raises `snap_pending_o` on the next cycle. From then on, the line-valid strobe is held inactive until a rising edge of `raw_vsync` with `raw_odd_field`=1. It is then passed for that field and the one following it.
- R7: At the rising edge of `raw_vsync` that ends the captured even field, the capture ends. `snap_pending_o` drops and line-valid passes ungated again.
- R8: A `snap_clear` pulse during the captured frame drops `snap_pending_o` but does not change `href_o` in that frame. A `snap_clear` pulse before the frame starts cancels the capture.
- R9: While `cfg_field_drop`=1, a `snap_set` pulse has no effect: `snap_pending_o` stays 0 and `href_o` stays ungated.
- R10: Every pin reflects the inputs sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_hsync | input | 1 | Raw horizontal sync, active high |
| raw_csync | input | 1 | Raw composite sync, active high |
| raw_vsync | input | 1 | Raw vertical sync, active high |
| raw_line_valid | input | 1 | Raw line-valid, active high |
| raw_odd_field | input | 1 | 1 during odd fields |
| cfg_sync_pol | input | 2 | Sync polarity pattern code |
| cfg_vs_frame | input | 1 | 1: vertical sync only in odd fields |
| cfg_chs_composite | input | 1 | 1: composite sync on chsync_o |
| cfg_href_invert | input | 1 | Invert href_o |
| cfg_field_drop | input | 1 | Field-drop mode active |
| snap_set | input | 1 | Pulse to request one frame capture |
| snap_clear | input | 1 | Pulse to withdraw the capture request |
| hsync_o | output | 1 | Horizontal sync pin |
| chsync_o | output | 1 | Horizontal or composite sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| href_o | output | 1 | Line-valid pin |
| snap_pending_o | output | 1 | Capture request flag |

## Verification
The bench sweeps all polarity codes together with every vertical-sync mode, selectable-sync choice and line-valid inversion. A swapped entry in the polarity table, or frame and field modes mixed up, shows up as a wrong pin level.

The capture tests target the following corner cases:
- A request raised during an odd field must wait a whole field before its frame begins. A design that started at any field boundary would begin the capture on the even field.
- A request withdrawn in mid-frame must leave that frame's lines whole. A design that gated on the flag itself would cut the lines short.
- The flag must drop exactly on the boundary that closes the frame. A late drop would gate one field too many.
- A request made during field-drop must leave no trace.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  localparam int POL_W    = 2;
  localparam int NUM_PINS = 4;
  localparam int PIN_HS   = 0;
  localparam int PIN_CHS  = 1;
  localparam int PIN_VS   = 2;
  localparam int PIN_HREF = 3;

  typedef enum logic [1:0] {
    SF_IDLE     = 2'd0,
    SF_ARMED    = 2'd1,
    SF_CAP_ODD  = 2'd2,
    SF_CAP_EVEN = 2'd3
  } sf_state_e;

  // invert mask for {vs, chs, hs}; a set bit means the pin idles high
  function automatic logic [2:0] sync_inv_mask(input logic [POL_W-1:0] code);
    logic [2:0] m;
    case (code)
      2'd0:    m = 3'b011;
      2'd1:    m = 3'b111;
      2'd2:    m = 3'b010;
      default: m = 3'b001;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vsg_rst_sync.sv
module vsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/vsg_field_edge.sv
module vsg_field_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_vs_i,
  output logic field_start_o
);

  logic vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= raw_vs_i;
  end

  assign field_start_o = raw_vs_i & ~vs_q;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_o |=> !field_start_o); // R6

endmodule

// File: rtl/vsg_sf_fsm.sv
module vsg_sf_fsm
  import vsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic drop_i,
  input  logic fs_i,
  input  logic odd_i,
  output logic pass_o,
  output logic pending_o
);

  sf_state_e st_q, st_d;
  logic      req_q, req_d;
  logic      st_en;

  always_comb begin
    st_d = st_q;
    req_d = req_q;
    case (st_q)
      SF_IDLE: begin
        if (set_i && !drop_i) begin
          st_d  = SF_ARMED;
          req_d = 1'b1;
        end
      end
      SF_ARMED: begin
        if (clr_i) begin
          st_d  = SF_IDLE;
          req_d = 1'b0;
        end else if (fs_i && odd_i) begin
          st_d  = SF_CAP_ODD;
        end
      end
      SF_CAP_ODD: begin
        if (clr_i) req_d = 1'b0;
        if (fs_i)  st_d  = SF_CAP_EVEN;
      end
      default: begin
        if (clr_i) req_d = 1'b0;
        if (fs_i) begin
          st_d  = SF_IDLE;
          req_d = 1'b0;
        end
      end
    endcase
  end

  assign st_en = (st_d != st_q) || (req_d != req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SF_IDLE;
      req_q <= 1'b0;
    end else if (st_en) begin
      st_q  <= st_d;
      req_q <= req_d;
    end
  end

  assign pass_o    = (st_d != SF_ARMED);
  assign pending_o = req_q;

  AST_DROP_IGNORES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SF_IDLE && drop_i) |=> (st_q == SF_IDLE && !req_q)); // R9
  AST_WAIT_FOR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SF_ARMED && !clr_i && !(fs_i && odd_i)) |=> (st_q == SF_ARMED)); // R6
  AST_END_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SF_CAP_EVEN && fs_i) |=> (st_q == SF_IDLE && !req_q)); // R7
  AST_CLEAR_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SF_CAP_ODD && clr_i && !fs_i) |=> (st_q == SF_CAP_ODD && !req_q)); // R8

endmodule

// File: rtl/vsg_pin_reg.sv
module vsg_pin_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] pin_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic d, q;
    always_comb d = act_i[g] ^ inv_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign pin_o[g] = q;
  end

endmodule

// File: rtl/video_sync_gate.sv
module video_sync_gate
  import vsg_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_hsync,
  input  logic             raw_csync,
  input  logic             raw_vsync,
  input  logic             raw_line_valid,
  input  logic             raw_odd_field,
  input  logic [POL_W-1:0] cfg_sync_pol,
  input  logic             cfg_vs_frame,
  input  logic             cfg_chs_composite,
  input  logic             cfg_href_invert,
  input  logic             cfg_field_drop,
  input  logic             snap_set,
  input  logic             snap_clear,
  output logic             hsync_o,
  output logic             chsync_o,
  output logic             vsync_o,
  output logic             href_o,
  output logic             snap_pending_o
);

  logic                rst_n_s;
  logic                field_start;
  logic                gate_pass;
  logic [2:0]          sync_inv;
  logic [NUM_PINS-1:0] act;
  logic [NUM_PINS-1:0] inv;
  logic [NUM_PINS-1:0] pins;

  vsg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  vsg_field_edge u_edge (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .raw_vs_i      (raw_vsync),
    .field_start_o (field_start)
  );

  vsg_sf_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_i     (snap_set),
    .clr_i     (snap_clear),
    .drop_i    (cfg_field_drop),
    .fs_i      (field_start),
    .odd_i     (raw_odd_field),
    .pass_o    (gate_pass),
    .pending_o (snap_pending_o)
  );

  always_comb begin
    sync_inv      = sync_inv_mask(cfg_sync_pol);
    act           = '0;
    act[PIN_HS]   = raw_hsync;
    act[PIN_CHS]  = cfg_chs_composite ? raw_csync : raw_hsync;
    act[PIN_VS]   = raw_vsync & (cfg_vs_frame ? raw_odd_field : 1'b1);
    act[PIN_HREF] = raw_line_valid & gate_pass;
    inv           = '0;
    inv[PIN_HS]   = sync_inv[0];
    inv[PIN_CHS]  = sync_inv[1];
    inv[PIN_VS]   = sync_inv[2];
    inv[PIN_HREF] = cfg_href_invert;
  end

  vsg_pin_reg #(.N(NUM_PINS)) u_pins (
    .clk   (clk),
    .rst_n (rst_n_s),
    .act_i (act),
    .inv_i (inv),
    .pin_o (pins)
  );

  assign hsync_o  = pins[PIN_HS];
  assign chsync_o = pins[PIN_CHS];
  assign vsync_o  = pins[PIN_VS];
  assign href_o   = pins[PIN_HREF];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |-> !(hsync_o | chsync_o | vsync_o | href_o | snap_pending_o)); // R1
  AST_ARMED_BLOCKS_HREF: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!gate_pass && !cfg_href_invert) |=> !href_o); // R6
  AST_EVEN_NO_VS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_vs_frame && !raw_odd_field && cfg_sync_pol == 2'd1) |=> vsync_o); // R3
  AST_HS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (raw_hsync && cfg_sync_pol == 2'd2) |=> hsync_o); // R10

endmodule

// File: tb/video_sync_gate_tb.sv
`timescale 1ns/1ps
module video_sync_gate_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic raw_hsync, raw_csync, raw_vsync, raw_line_valid, raw_odd_field;
  logic [1:0] cfg_sync_pol;
  logic cfg_vs_frame, cfg_chs_composite, cfg_href_invert, cfg_field_drop;
  logic snap_set, snap_clear;
  logic hsync_o, chsync_o, vsync_o, href_o, snap_pending_o;

  video_sync_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .raw_hsync(raw_hsync), .raw_csync(raw_csync), .raw_vsync(raw_vsync),
    .raw_line_valid(raw_line_valid), .raw_odd_field(raw_odd_field),
    .cfg_sync_pol(cfg_sync_pol), .cfg_vs_frame(cfg_vs_frame),
    .cfg_chs_composite(cfg_chs_composite), .cfg_href_invert(cfg_href_invert),
    .cfg_field_drop(cfg_field_drop), .snap_set(snap_set), .snap_clear(snap_clear),
    .hsync_o(hsync_o), .chsync_o(chsync_o), .vsync_o(vsync_o),
    .href_o(href_o), .snap_pending_o(snap_pending_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit checking = 0;
  bit finished = 0;
  int m_st = 0;
  bit m_req = 0;
  bit m_pvs = 0;
  int set_line = -1;
  int clr_line = -1;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock; model computed from the requirement text, outputs compared
  task automatic step();
    bit fs, pass, ihs, ichs, ivs;
    int nx;
    bit nreq;
    @(posedge clk);
    #1;
    if (checking) begin
      fs = raw_vsync && !m_pvs;
      nx = m_st;
      nreq = m_req;
      case (m_st)
        0: if (snap_set && !cfg_field_drop) begin nx = 1; nreq = 1; end
        1: if (snap_clear) begin nx = 0; nreq = 0; end
           else if (fs && raw_odd_field) nx = 2;
        2: begin if (snap_clear) nreq = 0; if (fs) nx = 3; end
        default: begin
          if (snap_clear) nreq = 0;
          if (fs) begin nx = 0; nreq = 0; end
        end
      endcase
      pass = (nx != 1);
      // active-low pins idle high: codes 0:(L,L,H) 1:(L,L,L) 2:(H,L,H) 3:(L,H,H)
      ihs  = (cfg_sync_pol != 2);
      ichs = (cfg_sync_pol != 3);
      ivs  = (cfg_sync_pol == 1);
      check("R2 R10 hsync", hsync_o, raw_hsync ^ ihs);
      check("R4 R2 chsync", chsync_o,
            (cfg_chs_composite ? raw_csync : raw_hsync) ^ ichs);
      check("R3 R2 vsync", vsync_o,
            (raw_vsync && (!cfg_vs_frame || raw_odd_field)) ^ ivs);
      check("R5 R6 R7 R8 href", href_o, (raw_line_valid && pass) ^ cfg_href_invert);
      check("R6 R7 R8 R9 pending", snap_pending_o, nreq);
      m_st = nx;
      m_req = nreq;
      m_pvs = raw_vsync;
    end
  endtask

  task automatic field(input bit odd, input int lines);
    raw_odd_field = odd;
    raw_vsync = 1; raw_csync = 1;
    repeat (3) step();
    raw_vsync = 0; raw_csync = 0;
    step();
    for (int l = 0; l < lines; l++) begin
      raw_hsync = 1; raw_csync = 1;
      repeat (2) step();
      raw_hsync = 0; raw_csync = 0;
      step();
      raw_line_valid = 1;
      snap_set = (l == set_line);
      snap_clear = (l == clr_line);
      step();
      snap_set = 0; snap_clear = 0;
      repeat (5) step();
      raw_line_valid = 0;
      repeat (2) step();
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    raw_hsync = 1; raw_csync = 1; raw_vsync = 1; raw_line_valid = 1; raw_odd_field = 1;
    cfg_sync_pol = 2'd1; cfg_vs_frame = 0; cfg_chs_composite = 0;
    cfg_href_invert = 1; cfg_field_drop = 0; snap_set = 1; snap_clear = 0;
    repeat (3) step();
    check("R1 hsync", hsync_o, 1'b0);
    check("R1 chsync", chsync_o, 1'b0);
    check("R1 vsync", vsync_o, 1'b0);
    check("R1 href", href_o, 1'b0);
    check("R1 pending", snap_pending_o, 1'b0);
    raw_hsync = 0; raw_csync = 0; raw_vsync = 0; raw_line_valid = 0; raw_odd_field = 0;
    snap_set = 0; cfg_href_invert = 0; cfg_sync_pol = 2'd0;
    #1 rst_n = 1;
    repeat (5) step();
    checking = 1;

    // sweep every configuration over one odd and one even field (R2 R3 R4 R5 R10)
    for (int c = 0; c < 32; c++) begin
      cfg_sync_pol = c[1:0];
      cfg_vs_frame = c[2];
      cfg_chs_composite = c[3];
      cfg_href_invert = c[4];
      field(1, 2);
      field(0, 2);
    end

    cfg_sync_pol = 0; cfg_vs_frame = 0; cfg_chs_composite = 0; cfg_href_invert = 0;

    // R6 R7: request in even field, capture next odd+even, then free running
    set_line = 1; field(0, 3); set_line = -1;
    check("R6 pending after set", snap_pending_o, 1'b1);
    field(1, 3);
    field(0, 3);
    check("R7 still pending inside frame", snap_pending_o, 1'b1);
    field(1, 3);
    check("R7 self clear at frame end", snap_pending_o, 1'b0);
    field(0, 3);

    // R6: request during an odd field waits for the next odd field
    cfg_href_invert = 1;
    set_line = 0; field(1, 3); set_line = -1;
    field(0, 3);
    field(1, 3);
    field(0, 3);
    field(1, 3);
    cfg_href_invert = 0;

    // R8: clear inside captured frame keeps the lines
    set_line = 2; field(0, 3); set_line = -1;
    clr_line = 1; field(1, 3); clr_line = -1;
    check("R8 flag dropped mid frame", snap_pending_o, 1'b0);
    field(0, 3);
    field(1, 3);

    // R8: clear before the frame cancels the capture
    set_line = 0; clr_line = 2; field(0, 3); set_line = -1; clr_line = -1;
    check("R8 cancelled while armed", snap_pending_o, 1'b0);
    field(1, 3);

    // R9: field drop ignores the request
    cfg_field_drop = 1;
    set_line = 1; field(0, 3); set_line = -1;
    check("R9 no pending under field drop", snap_pending_o, 1'b0);
    field(1, 3);
    cfg_field_drop = 0;
    field(0, 2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule